// File: doc/BRIEF.md
# Length-Prefixed Serial Command Frame Parser

This block sits behind a UART receiver and turns its byte stream into decoded control actions for a video mixer's controller. Every frame opens with a byte that gives the frame's total size, the length byte included. Three shapes of frame exist. A two-byte frame carries only a command number and produces a single command strobe. A five-byte frame asks for a register read and carries a byte count and a start address. A frame of N+5 bytes asks for a register write and carries N payload bytes. Read and write frames end with a checksum byte, which is the XOR of every byte after the length byte.

A write frame's payload is held in a small buffer until its checksum has been verified. Only then does the block raise a write request and replay the payload on consecutive cycles. Frames whose length is not legal, whose count disagrees with their length, or whose checksum does not match raise an error strobe and produce no request. The block then swallows the rest of the frame, as far as the length byte says. An inter-byte gap counter, driven by an external timeout tick, abandons a partly received frame so that the next byte is taken as a fresh length byte.

Top module: `cmdp_frame_parser`

## Requirements
- R1: While reset is low and in the first cycle after it, cmd_pulse, rd_req, wr_req, wr_data_valid and err_pulse are all 0.
- R2: A frame of length 2 (bytes 0x02, C) raises cmd_pulse for one cycle with cmd_code = C, one cycle after C is accepted. No other strobe is raised.
- R3: A frame of length 5 (0x05, C, N, A, S) with S equal to C^N^A raises rd_req for one cycle, with req_cmd = C, req_count = N and req_addr = A.
- R4: A frame of length N+5 with 1 <= N <= MAX_PAYLOAD and a correct checksum raises wr_req with req_cmd, req_count = N and req_addr. On the next N cycles wr_data_valid is high and the N payload bytes appear in arrival order, with wr_data_last set on the final byte only.
- R5: The checksum is the XOR of all bytes from the command number up to the byte before the checksum; the length byte is not part of it. On a mismatch the block raises err_pulse with err_kind = 2 and raises neither rd_req nor wr_req.
- R6: A length byte of 0, 1, 3, 4 or greater than MAX_PAYLOAD+5 raises err_pulse with err_kind = 1. For a length L >= 2, the next L-1 bytes are discarded without effect.
- R7: In a frame of length L > 5, a count byte different from L-5 raises err_pulse with err_kind = 1, and the remaining L-3 bytes of that frame are discarded.
- R8: Once GAP_TICKS gap_tick pulses have arrived since the last accepted byte of an unfinished frame, that frame is dropped without any strobe and the next byte is treated as a length byte. GAP_TICKS-1 pulses leave the frame intact.
- R9: gap_tick pulses while no frame is in progress have no effect on later frames.
- R10: At most one of cmd_pulse, rd_req, wr_req and err_pulse is high in any cycle, and each is high for only one cycle at a time.
- R11: The replay of a write payload is correct even while the next frame is already being received. This holds provided bytes arrive at least three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| gap_tick | input | 1 | Timeout tick pulse for the inter-byte gap counter |
| cmd_pulse | output | 1 | Short command decoded |
| cmd_code | output | 8 | Command number of the short command |
| rd_req | output | 1 | Read request accepted |
| wr_req | output | 1 | Write request accepted, payload follows |
| req_cmd | output | 8 | Command number of the read or write request |
| req_count | output | 8 | Byte count of the request |
| req_addr | output | 8 | Start address of the request |
| wr_data_valid | output | 1 | Payload byte valid |
| wr_data | output | 8 | Payload byte |
| wr_data_last | output | 1 | Final payload byte of the request |
| err_pulse | output | 1 | Frame rejected |
| err_kind | output | 2 | 1 = length or count error, 2 = checksum error |

## Verification
The hardest states to reach are the two that depend on timing rather than on byte values. One is a frame left unfinished right at the gap limit. The other is a payload replay that overlaps the reception of the next frame. The stimulus reaches the first by stopping partway through a read frame and issuing exactly GAP_TICKS-1 or GAP_TICKS tick pulses, then sending bytes that would parse differently in the two cases. It reaches the second by sending a full-size write frame directly followed by another write frame at the minimum byte spacing. Randomly shaped frames with occasional checksum corruption fill in the ordinary cases.

// File: rtl/cmdp_pkg.sv
`timescale 1ns/1ps
// Shared types for the command frame parser.
// Assumes: all frame fields are one byte wide.
package cmdp_pkg;

    // Parser position within a frame.
    typedef enum logic [2:0] {
        ST_LEN,
        ST_CMD,
        ST_CNT,
        ST_ADDR,
        ST_DATA,
        ST_SUM,
        ST_SKIP
    } cmdp_state_t;

    // Error classes reported on err_kind.
    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_LENGTH   = 2'd1,
        ERR_CHECKSUM = 2'd2
    } cmdp_err_t;

    // Header fields of a read or write request.
    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] count;
        logic [7:0] addr;
    } cmdp_req_t;

    localparam logic [7:0] SHORT_LEN   = 8'd2;
    localparam logic [7:0] READ_LEN    = 8'd5;
    localparam logic [7:0] WR_OVERHEAD = 8'd5;

endpackage

// File: rtl/cmdp_gap_timer.sv
`timescale 1ns/1ps
// Inter-byte gap timer.
// Counts gap_tick pulses while a frame is in progress. When the count
// reaches GAP_TICKS with no byte in between, it raises a one-cycle expire.
// Assumes: a byte arriving in the same cycle as the final tick wins.
module cmdp_gap_timer #(
    parameter int unsigned GAP_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic byte_seen,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Expire on the tick that completes the gap, unless a byte lands.
    assign expire = busy && !byte_seen && tick && (cnt_q == LAST);

    // Tick counter, cleared by any byte or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (byte_seen || !busy || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmdp_payload_buf.sv
`timescale 1ns/1ps
// Payload store and replay engine.
// Write bytes are stored by index while a frame is received. A start pulse
// replays the first `len` entries, one per cycle, with a last marker.
// Assumes: len >= 1. The replay reads index k before the next frame can
// write index k, which holds when bytes are spaced as stated for the top.
module cmdp_payload_buf #(
    parameter int unsigned MAX_PAYLOAD = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic       start,
    input  logic [7:0] len,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    localparam int unsigned AW = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;

    logic [7:0] mem [MAX_PAYLOAD];
    logic       active_q;
    logic [7:0] rptr_q;
    logic [7:0] len_q;
    logic       final_beat;

    assign final_beat = (rptr_q + 8'd1 == len_q);

    // Store incoming payload bytes.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr[AW-1:0]] <= wdata;
        end
    end

    // Replay control: pointer and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rptr_q   <= '0;
            len_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            rptr_q   <= '0;
            len_q    <= len;
        end else if (active_q) begin
            rptr_q <= rptr_q + 8'd1;
            if (final_beat) begin
                active_q <= 1'b0;
            end
        end
    end

    // Registered output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= active_q && !start;
            out_data  <= mem[rptr_q[AW-1:0]];
            out_last  <= active_q && !start && final_beat;
        end
    end

endmodule

// File: rtl/cmdp_frame_fsm.sv
`timescale 1ns/1ps
// Frame assembler and checker.
// Walks length, command, count, address, payload and checksum bytes. It
// keeps a running XOR, validates the length and count, and emits registered
// command, request and error strobes. Bad frames are drained by length.
// Assumes: MAX_PAYLOAD <= 250 so that every legal length fits in a byte.
module cmdp_frame_fsm
    import cmdp_pkg::*;
#(
    parameter int unsigned MAX_PAYLOAD = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       abort,
    output logic       busy,
    output logic       cmd_pulse,
    output logic [7:0] cmd_code,
    output logic       rd_req,
    output logic       wr_req,
    output cmdp_req_t  req,
    output logic       err_pulse,
    output cmdp_err_t  err_kind,
    output logic       buf_we,
    output logic [7:0] buf_waddr,
    output logic [7:0] buf_wdata,
    output logic       stream_start,
    output logic [7:0] stream_len
);
    localparam logic [7:0] MAX_LEN = 8'(MAX_PAYLOAD + 5);

    cmdp_state_t st_q;
    logic [7:0]  len_q;
    logic [7:0]  cmd_q;
    logic [7:0]  cnt_q;
    logic [7:0]  addr_q;
    logic [7:0]  csum_q;
    logic [7:0]  idx_q;
    logic [7:0]  remain_q;
    logic        sum_ok;
    logic        is_read;

    // Legal length test: short, read, or write within buffer size.
    function automatic logic len_legal(input logic [7:0] b);
        return (b == SHORT_LEN) || (b == READ_LEN) ||
               ((b > READ_LEN) && (b <= MAX_LEN));
    endfunction

    assign busy         = (st_q != ST_LEN);
    assign sum_ok       = (rx_byte == csum_q);
    assign is_read      = (len_q == READ_LEN);
    assign buf_we       = rx_valid && !abort && (st_q == ST_DATA);
    assign buf_waddr    = idx_q;
    assign buf_wdata    = rx_byte;
    assign stream_start = rx_valid && !abort && (st_q == ST_SUM) && sum_ok && !is_read;
    assign stream_len   = cnt_q;

    // Byte-by-byte frame walk with registered one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_LEN;
            len_q     <= '0;
            cmd_q     <= '0;
            cnt_q     <= '0;
            addr_q    <= '0;
            csum_q    <= '0;
            idx_q     <= '0;
            remain_q  <= '0;
            cmd_pulse <= 1'b0;
            cmd_code  <= '0;
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            req       <= '0;
            err_pulse <= 1'b0;
            err_kind  <= ERR_NONE;
        end else begin
            cmd_pulse <= 1'b0;
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            err_pulse <= 1'b0;
            if (abort) begin
                st_q <= ST_LEN;
            end else if (rx_valid) begin
                case (st_q)
                    ST_LEN: begin
                        len_q <= rx_byte;
                        if (len_legal(rx_byte)) begin
                            st_q <= ST_CMD;
                        end else begin
                            err_pulse <= 1'b1;
                            err_kind  <= ERR_LENGTH;
                            if (rx_byte >= 8'd2) begin
                                remain_q <= rx_byte - 8'd1;
                                st_q     <= ST_SKIP;
                            end
                        end
                    end
                    ST_CMD: begin
                        cmd_q  <= rx_byte;
                        csum_q <= rx_byte;
                        if (len_q == SHORT_LEN) begin
                            cmd_pulse <= 1'b1;
                            cmd_code  <= rx_byte;
                            st_q      <= ST_LEN;
                        end else begin
                            st_q <= ST_CNT;
                        end
                    end
                    ST_CNT: begin
                        cnt_q  <= rx_byte;
                        csum_q <= csum_q ^ rx_byte;
                        if (!is_read && (rx_byte != len_q - WR_OVERHEAD)) begin
                            err_pulse <= 1'b1;
                            err_kind  <= ERR_LENGTH;
                            remain_q  <= len_q - 8'd3;
                            st_q      <= ST_SKIP;
                        end else begin
                            st_q <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= rx_byte;
                        csum_q <= csum_q ^ rx_byte;
                        idx_q  <= '0;
                        st_q   <= is_read ? ST_SUM : ST_DATA;
                    end
                    ST_DATA: begin
                        csum_q <= csum_q ^ rx_byte;
                        idx_q  <= idx_q + 8'd1;
                        if (idx_q + 8'd1 == cnt_q) begin
                            st_q <= ST_SUM;
                        end
                    end
                    ST_SUM: begin
                        if (sum_ok) begin
                            rd_req <= is_read;
                            wr_req <= !is_read;
                            req    <= '{cmd: cmd_q, count: cnt_q, addr: addr_q};
                        end else begin
                            err_pulse <= 1'b1;
                            err_kind  <= ERR_CHECKSUM;
                        end
                        st_q <= ST_LEN;
                    end
                    ST_SKIP: begin
                        remain_q <= remain_q - 8'd1;
                        if (remain_q == 8'd1) begin
                            st_q <= ST_LEN;
                        end
                    end
                    default: st_q <= ST_LEN;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmdp_frame_parser.sv
`timescale 1ns/1ps
// Top of the length-prefixed command frame parser.
// Connects the frame walker, the payload replay buffer and the gap timer.
// Assumes: rx_valid is a one-cycle strobe. Strobes come at least three
// cycles apart, and 6*spacing exceeds MAX_PAYLOAD, so a replay ends before
// the next write request.
module cmdp_frame_parser #(
    parameter int unsigned MAX_PAYLOAD = 16,
    parameter int unsigned GAP_TICKS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       gap_tick,
    output logic       cmd_pulse,
    output logic [7:0] cmd_code,
    output logic       rd_req,
    output logic       wr_req,
    output logic [7:0] req_cmd,
    output logic [7:0] req_count,
    output logic [7:0] req_addr,
    output logic       wr_data_valid,
    output logic [7:0] wr_data,
    output logic       wr_data_last,
    output logic       err_pulse,
    output logic [1:0] err_kind
);
    import cmdp_pkg::*;

    logic       busy;
    logic       expire;
    logic       buf_we;
    logic [7:0] buf_waddr;
    logic [7:0] buf_wdata;
    logic       stream_start;
    logic [7:0] stream_len;
    cmdp_req_t  req;
    cmdp_err_t  err_code;

    assign req_cmd   = req.cmd;
    assign req_count = req.count;
    assign req_addr  = req.addr;
    assign err_kind  = err_code;

    cmdp_gap_timer #(
        .GAP_TICKS (GAP_TICKS)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .byte_seen (rx_valid),
        .tick      (gap_tick),
        .expire    (expire)
    );

    cmdp_frame_fsm #(
        .MAX_PAYLOAD (MAX_PAYLOAD)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .abort        (expire),
        .busy         (busy),
        .cmd_pulse    (cmd_pulse),
        .cmd_code     (cmd_code),
        .rd_req       (rd_req),
        .wr_req       (wr_req),
        .req          (req),
        .err_pulse    (err_pulse),
        .err_kind     (err_code),
        .buf_we       (buf_we),
        .buf_waddr    (buf_waddr),
        .buf_wdata    (buf_wdata),
        .stream_start (stream_start),
        .stream_len   (stream_len)
    );

    cmdp_payload_buf #(
        .MAX_PAYLOAD (MAX_PAYLOAD)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (buf_we),
        .waddr     (buf_waddr),
        .wdata     (buf_wdata),
        .start     (stream_start),
        .len       (stream_len),
        .out_valid (wr_data_valid),
        .out_data  (wr_data),
        .out_last  (wr_data_last)
    );

endmodule

// File: rtl/cmdp_frame_parser_chk.sv
`timescale 1ns/1ps
// Property checker for the frame parser, attached with bind.
// Watches only the top-level ports. It keeps its own beat counter to match
// replay length against the announced count.
module cmdp_frame_parser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       cmd_pulse,
    input logic       rd_req,
    input logic       wr_req,
    input logic [7:0] req_count,
    input logic       wr_data_valid,
    input logic       wr_data_last,
    input logic       err_pulse,
    input logic [1:0] err_kind
);
    logic [7:0] beats_q;
    logic [7:0] exp_cnt_q;

    // Count replay beats since the latest write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q   <= '0;
            exp_cnt_q <= '0;
        end else if (wr_req) begin
            beats_q   <= '0;
            exp_cnt_q <= req_count;
        end else if (wr_data_valid) begin
            beats_q <= wr_data_last ? 8'd0 : beats_q + 8'd1;
        end
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pulse, rd_req, wr_req, err_pulse}));

    a_r10_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse |=> !cmd_pulse);

    a_r2_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse || rd_req || wr_req || err_pulse) |-> $past(rx_valid));

    a_r4_replay_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_data_valid);

    a_r4_beats_match: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_valid && wr_data_last) |-> (beats_q + 8'd1 == exp_cnt_q));

    a_r4_replay_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_valid && wr_data_last) |=> !wr_data_valid);

    a_r6_err_coded: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_kind == 2'd1 || err_kind == 2'd2));

endmodule

bind cmdp_frame_parser cmdp_frame_parser_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .cmd_pulse     (cmd_pulse),
    .rd_req        (rd_req),
    .wr_req        (wr_req),
    .req_count     (req_count),
    .wr_data_valid (wr_data_valid),
    .wr_data_last  (wr_data_last),
    .err_pulse     (err_pulse),
    .err_kind      (err_kind)
);

// File: tb/sim_cmdp_frame_parser.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random frames.
module sim_cmdp_frame_parser;
    localparam int MAXP = 16;
    localparam int GAP  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       gap_tick = 1'b0;
    logic       cmd_pulse, rd_req, wr_req, wr_data_valid, wr_data_last, err_pulse;
    logic [7:0] cmd_code, req_cmd, req_count, req_addr, wr_data;
    logic [1:0] err_kind;

    int checks = 0;
    int fails  = 0;

    // Event log filled by the monitor.
    int         n_cmd, n_rd, n_wr, n_err, n_last;
    logic [7:0] m_cmd, m_rcmd, m_rcnt, m_radr;
    logic [1:0] m_err;
    logic [7:0] wq[$];

    always #2.5 clk = ~clk;

    cmdp_frame_parser #(.MAX_PAYLOAD(MAXP), .GAP_TICKS(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .gap_tick(gap_tick), .cmd_pulse(cmd_pulse), .cmd_code(cmd_code),
        .rd_req(rd_req), .wr_req(wr_req), .req_cmd(req_cmd),
        .req_count(req_count), .req_addr(req_addr),
        .wr_data_valid(wr_data_valid), .wr_data(wr_data),
        .wr_data_last(wr_data_last), .err_pulse(err_pulse), .err_kind(err_kind)
    );

    // Monitor samples outputs at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_pulse) begin n_cmd++; m_cmd = cmd_code; end
            if (rd_req) begin n_rd++; m_rcmd = req_cmd; m_rcnt = req_count; m_radr = req_addr; end
            if (wr_req) begin n_wr++; m_rcmd = req_cmd; m_rcnt = req_count; m_radr = req_addr; end
            if (wr_data_valid) begin wq.push_back(wr_data); if (wr_data_last) n_last++; end
            if (err_pulse) begin n_err++; m_err = err_kind; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        n_cmd = 0; n_rd = 0; n_wr = 0; n_err = 0; n_last = 0;
        m_cmd = 0; m_rcmd = 0; m_rcnt = 0; m_radr = 0; m_err = 0;
        wq.delete();
    endtask

    task automatic send_byte(input logic [7:0] b, input int idle);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] fr[$], input bit tight);
        foreach (fr[i]) send_byte(fr[i], tight ? 2 : 2 + int'($urandom % 3));
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); gap_tick = 1'b1;
            @(negedge clk); gap_tick = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (MAXP + 8) @(negedge clk);
    endtask

    function automatic logic [7:0] xor_body(input logic [7:0] fr[$]);
        logic [7:0] x = 8'h00;
        for (int i = 1; i < fr.size(); i++) x ^= fr[i];
        return x;
    endfunction

    function automatic int errs_total();
        return n_err;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] fr[$];
        logic [7:0] pay[$];
        logic [7:0] pay2[$];
        void'($urandom(32'd20417));
        clr();

        // R1: outputs idle during and right after reset.
        repeat (4) @(negedge clk);
        check({cmd_pulse, rd_req, wr_req, wr_data_valid, err_pulse} == 5'b0, "R1 reset strobes",
              {cmd_pulse, rd_req, wr_req, wr_data_valid, err_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cmd_pulse, rd_req, wr_req, wr_data_valid, err_pulse} == 5'b0, "R1 after reset",
              {cmd_pulse, rd_req, wr_req, wr_data_valid, err_pulse}, 0);

        // R2: short command.
        clr(); fr = '{8'h02, 8'h01}; send_frame(fr, 0); settle();
        check(n_cmd == 1 && m_cmd == 8'h01, "R2 short cmd", m_cmd, 8'h01);
        check(n_rd + n_wr + n_err == 0, "R2 no other strobe", n_rd + n_wr + n_err, 0);

        // R3: read frame example.
        clr(); fr = '{8'h05, 8'h0B, 8'h04, 8'h00, 8'h0F}; send_frame(fr, 0); settle();
        check(n_rd == 1 && m_rcmd == 8'h0B && m_rcnt == 8'h04 && m_radr == 8'h00,
              "R3 read fields", {m_rcmd, m_rcnt, m_radr}, 24'h0B0400);

        // R4: write frame example.
        clr(); fr = '{8'h09, 8'h0C, 8'h04, 8'h27, 8'h00, 8'h21, 8'h1D, 8'h00, 8'h13};
        send_frame(fr, 0); settle();
        check(n_wr == 1 && m_rcmd == 8'h0C && m_rcnt == 8'h04 && m_radr == 8'h27,
              "R4 write fields", {m_rcmd, m_rcnt, m_radr}, 24'h0C0427);
        check(wq.size() == 4 && wq[0] == 8'h00 && wq[1] == 8'h21 && wq[2] == 8'h1D && wq[3] == 8'h00,
              "R4 write payload", wq.size(), 4);
        check(n_last == 1, "R4 last marker", n_last, 1);

        // R5: checksum mismatch on read.
        clr(); fr = '{8'h05, 8'h0B, 8'h04, 8'h00, 8'h0E}; send_frame(fr, 0); settle();
        check(n_err == 1 && m_err == 2'd2 && n_rd == 0, "R5 bad checksum", {n_err, m_err}, 12);

        // R6: illegal length 3 swallows two bytes that look like a command.
        clr(); fr = '{8'h03, 8'h02, 8'h01}; send_frame(fr, 0);
        fr = '{8'h02, 8'h05}; send_frame(fr, 0); settle();
        check(n_err == 1 && m_err == 2'd1, "R6 length 3 error", {n_err, m_err}, 11);
        check(n_cmd == 1 && m_cmd == 8'h05, "R6 swallowed bytes", m_cmd, 8'h05);

        // R6: length 0 resynchronises at once.
        clr(); fr = '{8'h00, 8'h02, 8'h09}; send_frame(fr, 0); settle();
        check(n_err == 1 && n_cmd == 1 && m_cmd == 8'h09, "R6 length 0", m_cmd, 8'h09);

        // R6: oversize write length swallowed.
        clr(); fr = '{8'(MAXP + 6)};
        for (int i = 0; i < MAXP + 5; i++) fr.push_back(8'h02);
        send_frame(fr, 0); fr = '{8'h02, 8'h33}; send_frame(fr, 0); settle();
        check(n_err == 1 && m_err == 2'd1 && n_cmd == 1 && m_cmd == 8'h33 && n_wr == 0,
              "R6 oversize length", n_cmd, 1);

        // R7: count disagrees with length.
        clr(); fr = '{8'h07, 8'h0C, 8'h03, 8'h02, 8'h01, 8'h02, 8'h01};
        send_frame(fr, 0); fr = '{8'h02, 8'h44}; send_frame(fr, 0); settle();
        check(n_err == 1 && m_err == 2'd1 && n_wr == 0, "R7 count mismatch", {n_err, m_err}, 11);
        check(n_cmd == 1 && m_cmd == 8'h44, "R7 remainder swallowed", m_cmd, 8'h44);

        // R8: GAP ticks discard a partial frame.
        clr(); send_byte(8'h05, 2); send_byte(8'h0B, 2); tick_n(GAP);
        fr = '{8'h02, 8'h07}; send_frame(fr, 0); settle();
        check(n_cmd == 1 && m_cmd == 8'h07 && n_rd == 0 && n_err == 0, "R8 timeout discard", m_cmd, 8'h07);

        // R8: one tick fewer keeps the frame.
        clr(); send_byte(8'h05, 2); send_byte(8'h0B, 2); tick_n(GAP - 1);
        fr = '{8'h04, 8'h00, 8'h0F}; send_frame(fr, 0); settle();
        check(n_rd == 1 && m_rcnt == 8'h04 && n_err == 0, "R8 below limit kept", n_rd, 1);

        // R9: ticks while idle have no effect.
        clr(); tick_n(3 * GAP);
        check(n_cmd + n_rd + n_wr + n_err == 0, "R9 idle ticks quiet", n_cmd + n_rd + n_wr + n_err, 0);
        fr = '{8'h05, 8'h0B, 8'h04, 8'h00, 8'h0F}; send_frame(fr, 0); settle();
        check(n_rd == 1 && n_err == 0, "R9 frame after idle ticks", n_rd, 1);

        // R11: full write followed tightly by another write.
        clr(); pay.delete(); pay2.delete();
        for (int i = 0; i < MAXP; i++) pay.push_back(8'($urandom));
        fr = '{8'(MAXP + 5), 8'h0C, 8'(MAXP), 8'h10}; foreach (pay[i]) fr.push_back(pay[i]);
        fr.push_back(xor_body(fr)); send_frame(fr, 1);
        for (int i = 0; i < 3; i++) pay2.push_back(8'($urandom));
        fr = '{8'h08, 8'h0D, 8'h03, 8'h20}; foreach (pay2[i]) fr.push_back(pay2[i]);
        fr.push_back(xor_body(fr)); send_frame(fr, 1); settle();
        begin
            bit same;
            same = (wq.size() == MAXP + 3);
            for (int i = 0; i < MAXP && same; i++) same = (wq[i] == pay[i]);
            for (int i = 0; i < 3 && same; i++) same = (wq[MAXP + i] == pay2[i]);
            check(same && n_wr == 2 && n_last == 2, "R11 overlapped replay", wq.size(), MAXP + 3);
        end

        // Random frames, R2 R3 R4 R5.
        for (int it = 0; it < 60; it++) begin
            int         kind;
            int         n;
            bit         bad;
            logic [7:0] c, a;
            kind = int'($urandom % 3);
            c = 8'($urandom); a = 8'($urandom);
            n = 1 + int'($urandom % MAXP);
            bad = ($urandom % 4) == 0;
            clr(); pay.delete();
            if (kind == 0) begin
                fr = '{8'h02, c}; send_frame(fr, 0); settle();
                check(n_cmd == 1 && m_cmd == c && n_err == 0, "R2 random short", m_cmd, c);
            end else begin
                if (kind == 1) fr = '{8'h05, c, 8'(n), a};
                else begin
                    fr = '{8'(n + 5), c, 8'(n), a};
                    for (int i = 0; i < n; i++) begin pay.push_back(8'($urandom)); fr.push_back(pay[i]); end
                end
                fr.push_back(xor_body(fr) ^ (bad ? (8'h01 << ($urandom % 8)) : 8'h00));
                send_frame(fr, 0); settle();
                if (bad) begin
                    check(errs_total() == 1 && m_err == 2'd2 && n_rd + n_wr == 0, "R5 random corrupt", n_err, 1);
                end else if (kind == 1) begin
                    check(n_rd == 1 && m_rcmd == c && m_rcnt == 8'(n) && m_radr == a, "R3 random read",
                          {m_rcmd, m_rcnt, m_radr}, {c, 8'(n), a});
                end else begin
                    bit same;
                    same = (wq.size() == n) && n_wr == 1 && m_rcmd == c && m_radr == a && n_last == 1;
                    for (int i = 0; i < n && same; i++) same = (wq[i] == pay[i]);
                    check(same, "R4 random write", wq.size(), n);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule